// File: doc/BRIEF.md
# Port Disconnect Supervisor

This block watches a set of powered ports and decides when a port should be switched off because its powered device has been unplugged. Each port has two presence-sensing methods, each with its own enable. A DC method uses a flag that reports that the port current is below a minimum. An AC method uses a flag that reports that the AC sense current is below its own minimum. For each method, the low condition must persist for a programmable number of clock cycles before that method counts the device as gone.

Each enabled method casts a "still present" vote. The votes are ORed together, so any one enabled method that still sees the device keeps the port on. A port with neither method enabled is never switched off by this block. When every enabled method has qualified its low condition, the block issues a single-cycle turn-off request for that port. It then stays quiet until the port has been unpowered and powered again. One supervisor instance is generated per port. All instances share a single enable vector, and each port's state is independent of the other ports.

Top module: `disconnect_supervisor`

## Requirements
- R1: After reset, and on every clock edge after reset, `off_req` is all zeros until some port meets its turn-off condition.
- R2: If only the DC method is enabled for port i, `off_req[i]` pulses after the edge at which `dc_low[i]` has been sampled high for DC_CYCLES+1 consecutive edges while the port is powered. A run of DC_CYCLES samples or fewer produces no request.
- R3: If only the AC method is enabled for port i, `off_req[i]` pulses after the edge at which `ac_low[i]` has been sampled high for AC_CYCLES+1 consecutive edges while the port is powered. A shorter run produces no request.
- R4: If both methods are enabled, no request is issued while either enabled method still sees the device. The request fires at the first edge at which both methods have qualified.
- R5: If neither method is enabled for a port, that port never receives a request, whatever its low flags show.
- R6: A sample with the low flag clear restarts that method's qualification count from zero.
- R7: An unpowered port receives no request. Losing power clears both of its qualification counts.
- R8: A request is exactly one cycle wide and is issued at most once per powered period. After the port is unpowered and powered again, it can be issued once more.
- R9: Bit i of `dis_en` enables the DC method for port i, and bit N_PORTS+i enables the AC method for port i. Ports act independently of one another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dis_en | input | 2*N_PORTS | Method enables: DC in the low half, AC in the high half |
| dc_low | input | N_PORTS | Port current below the DC minimum, one bit per port |
| ac_low | input | N_PORTS | AC sense current below the AC minimum, one bit per port |
| powered | input | N_PORTS | Port is currently powered |
| off_req | output | N_PORTS | Single-cycle turn-off request, one bit per port |

## Verification
The bench tries every combination of the two enables and the two low flags on every port, with the other ports held unpowered. This tells apart the OR of the presence votes, the per-method thresholds, and any crossing between the bits of the enable vector. Runs that stop one sample short of a threshold, or that are broken by a single present sample, separate "longer than" from "at least" and show whether the count really restarts. Removing and restoring power in the middle of a count, and again after a request, shows that the counts clear and that the request re-arms.

// File: rtl/disc_pkg.sv
package disc_pkg;

  typedef struct packed {
    logic powered;
    logic dc_en;
    logic ac_en;
    logic dc_low;
    logic ac_low;
  } disc_port_in_t;

endpackage

// File: rtl/disc_qual_timer.sv
module disc_qual_timer #(
  parameter int LIMIT = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic low,
  output logic qualified
);

  localparam int CNT_W = (LIMIT < 1) ? 1 : $clog2(LIMIT + 1);
  localparam logic [CNT_W-1:0] LIM_V = CNT_W'(LIMIT);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;
  logic             run;
  logic             at_lim;

  always_comb begin
    run    = arm & low;
    at_lim = (cnt_q == LIM_V);
    if (run) begin
      cnt_d  = at_lim ? cnt_q : cnt_q + 1'b1;
      cnt_en = ~at_lim;
    end else begin
      cnt_d  = '0;
      cnt_en = (cnt_q != '0);
    end
    // the current sample completes the run once LIMIT earlier samples are in
    qualified = run & at_lim;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/disc_port_sup.sv
module disc_port_sup
  import disc_pkg::*;
#(
  parameter int DC_CYCLES = 8,
  parameter int AC_CYCLES = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  disc_port_in_t pin,
  output logic          off_req
);

  logic dc_gone;
  logic ac_gone;
  logic fire;
  logic fired_q;
  logic fired_d;
  logic req_d;
  logic req_q;

  disc_qual_timer #(.LIMIT(DC_CYCLES)) u_dc_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .arm       (pin.powered & pin.dc_en),
    .low       (pin.dc_low),
    .qualified (dc_gone)
  );

  disc_qual_timer #(.LIMIT(AC_CYCLES)) u_ac_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .arm       (pin.powered & pin.ac_en),
    .low       (pin.ac_low),
    .qualified (ac_gone)
  );

  always_comb begin
    // every enabled method must have lost the device; at least one enabled
    fire = pin.powered & (pin.dc_en | pin.ac_en)
         & (~pin.dc_en | dc_gone) & (~pin.ac_en | ac_gone);
    req_d   = fire & ~fired_q;
    fired_d = pin.powered & (fired_q | fire);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fired_q <= 1'b0;
      req_q   <= 1'b0;
    end else begin
      fired_q <= fired_d;
      req_q   <= req_d;
    end
  end

  assign off_req = req_q;

endmodule

// File: rtl/disconnect_supervisor.sv
module disconnect_supervisor
  import disc_pkg::*;
#(
  parameter int N_PORTS   = 4,
  parameter int DC_CYCLES = 8,
  parameter int AC_CYCLES = 12
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [2*N_PORTS-1:0]   dis_en,
  input  logic [N_PORTS-1:0]     dc_low,
  input  logic [N_PORTS-1:0]     ac_low,
  input  logic [N_PORTS-1:0]     powered,
  output logic [N_PORTS-1:0]     off_req
);

  disc_port_in_t port_in [N_PORTS];

  for (genvar g = 0; g < N_PORTS; g++) begin : g_port
    always_comb begin
      port_in[g].powered = powered[g];
      port_in[g].dc_en   = dis_en[g];
      port_in[g].ac_en   = dis_en[N_PORTS + g];
      port_in[g].dc_low  = dc_low[g];
      port_in[g].ac_low  = ac_low[g];
    end

    disc_port_sup #(
      .DC_CYCLES (DC_CYCLES),
      .AC_CYCLES (AC_CYCLES)
    ) u_sup (
      .clk     (clk),
      .rst_n   (rst_n),
      .pin     (port_in[g]),
      .off_req (off_req[g])
    );
  end

endmodule

// File: rtl/disconnect_supervisor_chk.sv
module disconnect_supervisor_chk #(
  parameter int N_PORTS = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [2*N_PORTS-1:0] dis_en,
  input logic [N_PORTS-1:0]   dc_low,
  input logic [N_PORTS-1:0]   ac_low,
  input logic [N_PORTS-1:0]   powered,
  input logic [N_PORTS-1:0]   off_req
);

  for (genvar g = 0; g < N_PORTS; g++) begin : g_chk
    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      off_req[g] |=> !off_req[g]); // R8
    AST_NEEDS_POWER: assert property (@(posedge clk) disable iff (!rst_n)
      off_req[g] |-> $past(powered[g])); // R7
    AST_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
      off_req[g] |-> ($past(dis_en[g]) || $past(dis_en[N_PORTS + g]))); // R5
    AST_DC_PRESENCE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (off_req[g] && $past(dis_en[g])) |-> $past(dc_low[g])); // R4
    AST_AC_PRESENCE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (off_req[g] && $past(dis_en[N_PORTS + g])) |-> $past(ac_low[g])); // R4
  end

endmodule

bind disconnect_supervisor disconnect_supervisor_chk #(.N_PORTS(N_PORTS)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .dis_en  (dis_en),
  .dc_low  (dc_low),
  .ac_low  (ac_low),
  .powered (powered),
  .off_req (off_req)
);

// File: tb/test_disconnect_supervisor.sv
`timescale 1ns/1ps
module test_disconnect_supervisor;

  localparam int N    = 4;
  localparam int DC_T = 5;
  localparam int AC_T = 7;

  logic           clk;
  logic           rst_n;
  logic [2*N-1:0] dis_en;
  logic [N-1:0]   dc_low;
  logic [N-1:0]   ac_low;
  logic [N-1:0]   powered;
  logic [N-1:0]   off_req;

  int checks;
  int failures;
  int pulses;
  int first_cyc;
  int others;

  disconnect_supervisor #(.N_PORTS(N), .DC_CYCLES(DC_T), .AC_CYCLES(AC_T)) i_disconnect_supervisor (
    .clk     (clk),
    .rst_n   (rst_n),
    .dis_en  (dis_en),
    .dc_low  (dc_low),
    .ac_low  (ac_low),
    .powered (powered),
    .off_req (off_req)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  initial begin
    #(200000 * 10);
    failures++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // steps n edges, samples 1 ns after each edge, counts pulses on port p
  task automatic watch(input int n, input int p);
    pulses = 0; first_cyc = 0; others = 0;
    for (int c = 1; c <= n; c++) begin
      @(posedge clk); #1;
      if (off_req[p]) begin
        pulses++;
        if (first_cyc == 0) first_cyc = c;
      end
      for (int q = 0; q < N; q++) if (q != p && off_req[q]) others++;
    end
  endtask

  task automatic idle();
    dis_en = '0; dc_low = '0; ac_low = '0; powered = '0;
    watch(2, 0);
  endtask

  task automatic arm_port(input int p, input bit dce, input bit ace, input bit dcl, input bit acl);
    dis_en[p] = dce; dis_en[N+p] = ace;
    dc_low[p] = dcl; ac_low[p] = acl;
    powered[p] = 1'b1;
  endtask

  initial begin
    checks = 0; failures = 0;
    rst_n = 1'b0;
    dis_en = '0; dc_low = '0; ac_low = '0; powered = '0;
    #23;
    check("R1 reset", int'(off_req), 0);
    @(negedge clk); rst_n = 1'b1;
    watch(3, 0);
    check("R1 after reset", pulses + others, 0);

    // sweep: every port, every enable and low-flag combination
    for (int p = 0; p < N; p++) begin
      for (int cfg = 0; cfg < 16; cfg++) begin
        bit dce, ace, dcl, acl, exp_fire;
        int exp_cyc;
        string tag;
        dce = cfg[0]; ace = cfg[1]; dcl = cfg[2]; acl = cfg[3];
        exp_fire = (dce | ace) & (~dce | dcl) & (~ace | acl);
        exp_cyc = 0;
        if (dce && DC_T + 1 > exp_cyc) exp_cyc = DC_T + 1;
        if (ace && AC_T + 1 > exp_cyc) exp_cyc = AC_T + 1;
        if (!exp_fire) exp_cyc = 0;
        tag = (!dce && !ace) ? "R5" : (dce && ace) ? "R4" : dce ? "R2" : "R3";
        idle();
        arm_port(p, dce, ace, dcl, acl);
        watch(AC_T + 8, p);
        check($sformatf("%s port%0d cfg%0d pulses", tag, p, cfg), pulses, int'(exp_fire));
        check($sformatf("%s port%0d cfg%0d cycle", tag, p, cfg), first_cyc, exp_cyc);
        check($sformatf("R9 port%0d cfg%0d other ports", p, cfg), others, 0);
      end
    end

    // R2 boundary: exactly DC_T low samples then present
    idle();
    arm_port(1, 1, 0, 1, 0);
    watch(DC_T, 1);
    dc_low[1] = 1'b0;
    watch(10, 1);
    check("R2 short run no request", pulses, 0);

    // R3 boundary: exactly AC_T low samples then present
    idle();
    arm_port(2, 0, 1, 0, 1);
    watch(AC_T, 2);
    ac_low[2] = 1'b0;
    watch(10, 2);
    check("R3 short run no request", pulses, 0);

    // R6 restart after one present sample
    idle();
    arm_port(0, 1, 0, 1, 0);
    watch(DC_T, 0);
    check("R6 before break", pulses, 0);
    dc_low[0] = 1'b0;
    watch(1, 0);
    dc_low[0] = 1'b1;
    watch(DC_T + 4, 0);
    check("R6 restart cycle", first_cyc, DC_T + 1);

    // R4 AC present keeps port while DC long gone, then AC leaves
    idle();
    arm_port(3, 1, 1, 1, 0);
    watch(AC_T + 4, 3);
    check("R4 AC presence holds", pulses, 0);
    ac_low[3] = 1'b1;
    watch(AC_T + 4, 3);
    check("R4 fires when AC qualifies", first_cyc, AC_T + 1);

    // R7 power loss mid-count clears count
    idle();
    arm_port(1, 1, 0, 1, 0);
    watch(DC_T, 1);
    powered[1] = 1'b0;
    watch(1, 1);
    check("R7 no request while unpowered", pulses, 0);
    powered[1] = 1'b1;
    watch(DC_T + 4, 1);
    check("R7 count restarted", first_cyc, DC_T + 1);

    // R7 unpowered with low flags and enables never requests
    idle();
    dis_en = '1; dc_low = '1; ac_low = '1; powered = '0;
    watch(AC_T + 6, 0);
    check("R7 unpowered all ports", pulses + others, 0);

    // R8 single pulse, then re-arm after power cycle
    idle();
    arm_port(2, 1, 0, 1, 0);
    watch(DC_T + 10, 2);
    check("R8 one pulse", pulses, 1);
    powered[2] = 1'b0;
    watch(1, 2);
    powered[2] = 1'b1;
    watch(DC_T + 4, 2);
    check("R8 re-armed", first_cyc, DC_T + 1);
    check("R8 re-armed single", pulses, 1);

    // R9 all ports at once, different methods per port
    idle();
    arm_port(0, 1, 0, 1, 0);
    arm_port(1, 0, 1, 0, 1);
    arm_port(2, 1, 1, 1, 1);
    arm_port(3, 0, 0, 1, 1);
    watch(AC_T + 4, 0);
    check("R9 port0 DC", first_cyc, DC_T + 1);
    idle();
    arm_port(0, 1, 0, 1, 0);
    arm_port(1, 0, 1, 0, 1);
    arm_port(2, 1, 1, 1, 1);
    arm_port(3, 0, 0, 1, 1);
    watch(AC_T + 4, 1);
    check("R9 port1 AC", first_cyc, AC_T + 1);
    check("R9 others fired", others, 2);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule